// File: doc/BRIEF.md
# Dadda Tree Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. An array of AND gates forms all N x N partial-product bits. The bit columns are then compressed in stages of full and half adders until no column holds more than two bits. A final carry-propagate adder sums the two remaining rows. The number of stages and the adder placement are fixed when the design is built, from the operand width alone.

The height limits for the stages come from a sequence that starts at 2 and grows backwards. Each term is the floor of 1.5 times the term after it: 2, 3, 4, 6, 9, 13, and so on. The first stage targets the largest term below N, and each later stage targets the next smaller term. A column gets only enough counters to bring its height, counting the carries arriving from the column below, down to the stage target.

Both operands are captured in registers on the same clock as the product register. A result therefore appears two rising edges after its operands are applied, and a new operand pair can be accepted on every cycle. A parameter chooses the final adder: a plain behavioural sum, or a split adder. The split adder ripples through the low half-operand bits and uses carry-select blocks above them.

Top module: `dadda_mul`

## Requirements
- R1: While rst_n is low, the operand and product registers are cleared asynchronously and product reads zero, whatever the operands are.
- R2: For any operands A and B, product equals A*B as an unsigned 2N-bit value two rising clock edges after A and B are presented.
- R3: A different operand pair can be presented on every cycle, and the results come out back-to-back in the same order.
- R4: Operand changes between two rising edges, if undone before the next edge, have no effect on any later product.
- R5: The compression tree applies the stage targets 2, 3, 4, 6, 9, 13... from the largest term below N down to 2. It leaves two rows whose 2N-bit sum equals the product of the registered operands.
- R6: With ADDER_KIND=1, the final adder ripples through its low N/2 bits and adds the upper bits in carry-select blocks of N/2 bits. Each block picks its precomputed sum by the carry arriving from below, and the result equals the binary sum of the two rows.
- R7: A zero operand gives a zero product, and two all-ones operands give (2^N-1)^2, which is 0xFE01 for N=8 and 0xFFFE0001 for N=16.
- R8: With ADDER_KIND=0, the final adder is a behavioural sum, and every product is identical to the ADDER_KIND=1 result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the operand and product registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | N | Multiplicand |
| op_b | input | N | Multiplier |
| product | output | 2N | Registered unsigned product |

## Verification
The bench builds three copies of the block:
- N=8 with the split final adder. All 65536 operand pairs are swept back-to-back, which covers every column height and every carry path of the 8-bit tree.
- N=16 with the split adder, which reaches the six-stage tree and three carry-select blocks.
- N=16 with the behavioural adder, as a second route to the same products.

The two N=16 copies receive random operands plus all-ones and zero corners. Directed steps cover reset while operands are non-zero, and operand glitches between edges.

// File: rtl/dadda_mul_pkg.sv
`timescale 1ns/1ps
package dadda_mul_pkg;

    localparam int MAXCOL = 512;

    // Number of reduction stages: sequence terms (2,3,4,6,...) below n.
    function automatic int stage_count(input int n);
        int d;
        int k;
        d = 2;
        k = 0;
        while (d < n) begin
            k++;
            d = (d * 3) / 2;
        end
        return k;
    endfunction

    // Height target of stage st (0 = first stage, tallest target).
    function automatic int stage_target(input int n, input int st);
        int d;
        int k;
        d = 2;
        k = stage_count(n) - 1 - st;
        for (int i = 0; i < k; i++) d = (d * 3) / 2;
        return d;
    endfunction

    // Bits in column c of the initial partial-product matrix.
    function automatic int init_height(input int n, input int c);
        int lo;
        int hi;
        if (c > 2 * n - 2) return 0;
        lo = (c - n + 1 > 0) ? c - n + 1 : 0;
        hi = (c < n - 1) ? c : n - 1;
        return hi - lo + 1;
    endfunction

    // sel 0: column height entering stage s; 1: full adders; 2: half adders.
    function automatic int plan_val(input int n, input int s, input int c, input int sel);
        int h  [MAXCOL];
        int fa [MAXCOL];
        int ha [MAXCOL];
        int cin;
        int e;
        int d;
        for (int k = 0; k < 2 * n; k++) begin
            h[k]  = init_height(n, k);
            fa[k] = 0;
            ha[k] = 0;
        end
        for (int st = 0; st <= s; st++) begin
            if (st == s && sel == 0) return h[c];
            d = stage_target(n, st);
            for (int k = 0; k < 2 * n; k++) begin
                cin = (k > 0) ? fa[k-1] + ha[k-1] : 0;
                e = h[k] + cin - d;
                if (e > 0) begin
                    fa[k] = e / 2;
                    ha[k] = e % 2;
                end else begin
                    fa[k] = 0;
                    ha[k] = 0;
                end
            end
            if (st == s) return (sel == 1) ? fa[c] : ha[c];
            for (int k = 2 * n - 1; k >= 0; k--) begin
                cin = (k > 0) ? fa[k-1] + ha[k-1] : 0;
                h[k] = h[k] - 2 * fa[k] - ha[k] + cin;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/dm_pp_array.sv
`timescale 1ns/1ps
module dm_pp_array #(
    parameter int N = 8
) (
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [N*N-1:0] pp
);
    // pp[i*N+j] carries weight 2^(i+j)
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_bit
            assign pp[i*N+j] = a[i] & b[j];
        end
    end
endmodule

// File: rtl/dm_csa_cell.sv
`timescale 1ns/1ps
module dm_csa_cell (
    input  logic x,
    input  logic y,
    input  logic z,
    output logic sum,
    output logic carry
);
    // Tie z low for a half adder.
    assign sum   = x ^ y ^ z;
    assign carry = (x & y) | (z & (x ^ y));
endmodule

// File: rtl/dm_reduce.sv
`timescale 1ns/1ps
module dm_reduce
    import dadda_mul_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N*N-1:0] pp,
    output logic [2*N-1:0] row0,
    output logic [2*N-1:0] row1
);
    localparam int NS = stage_count(N);
    localparam int NC = 2 * N;

    // mat[s][c][r]: row r of column c entering stage s
    logic [N-1:0] mat [NS+1][NC];

    // Stage 0: gather the AND array into columns.
    for (genvar c = 0; c < NC; c++) begin : g_init
        localparam int H0 = init_height(N, c);
        localparam int LO = (c - N + 1 > 0) ? c - N + 1 : 0;
        for (genvar r = 0; r < N; r++) begin : g_r
            if (r < H0) begin : g_pp
                assign mat[0][c][r] = pp[(LO + r) * N + (c - LO - r)];
            end else begin : g_zero
                assign mat[0][c][r] = 1'b0;
            end
        end
    end

    for (genvar s = 0; s < NS; s++) begin : g_stage
        logic [N-1:0] sm_w [NC];
        logic [N-1:0] cy_w [NC];
        for (genvar c = 0; c < NC; c++) begin : g_col
            localparam int H   = plan_val(N, s, c, 0);
            localparam int FA  = plan_val(N, s, c, 1);
            localparam int HA  = plan_val(N, s, c, 2);
            localparam int FAP = (c > 0) ? plan_val(N, s, c - 1, 1) : 0;
            localparam int HAP = (c > 0) ? plan_val(N, s, c - 1, 2) : 0;
            localparam int USED = 3 * FA + 2 * HA;
            localparam int PASS = H - USED;
            localparam int CIN  = FAP + HAP;

            for (genvar k = 0; k < N; k++) begin : g_cell
                if (k < FA) begin : g_fa
                    dm_csa_cell u_fa (
                        .x     (mat[s][c][3*k]),
                        .y     (mat[s][c][3*k+1]),
                        .z     (mat[s][c][3*k+2]),
                        .sum   (sm_w[c][k]),
                        .carry (cy_w[c][k])
                    );
                end else if (k < FA + HA) begin : g_ha
                    dm_csa_cell u_ha (
                        .x     (mat[s][c][3*FA + 2*(k-FA)]),
                        .y     (mat[s][c][3*FA + 2*(k-FA) + 1]),
                        .z     (1'b0),
                        .sum   (sm_w[c][k]),
                        .carry (cy_w[c][k])
                    );
                end else begin : g_none
                    assign sm_w[c][k] = 1'b0;
                    assign cy_w[c][k] = 1'b0;
                end
            end

            // Next column order: sums, untouched bits, carries from c-1.
            for (genvar r = 0; r < N; r++) begin : g_next
                if (r < FA + HA) begin : g_sum
                    assign mat[s+1][c][r] = sm_w[c][r];
                end else if (r < FA + HA + PASS) begin : g_pass
                    assign mat[s+1][c][r] = mat[s][c][USED + r - FA - HA];
                end else if (r < FA + HA + PASS + CIN) begin : g_cy
                    assign mat[s+1][c][r] = cy_w[c-1][r - FA - HA - PASS];
                end else begin : g_zero
                    assign mat[s+1][c][r] = 1'b0;
                end
            end
        end
    end

    for (genvar c = 0; c < NC; c++) begin : g_out
        assign row0[c] = mat[NS][c][0];
        assign row1[c] = mat[NS][c][1];
    end
endmodule

// File: rtl/dm_final_add.sv
`timescale 1ns/1ps
module dm_final_add #(
    parameter int W     = 16,
    parameter int KIND  = 1,
    parameter int LOW_W = 4,
    parameter int BLK_W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s
);
    localparam int NB = (W - LOW_W + BLK_W - 1) / BLK_W;

    if (KIND == 0) begin : g_behav
        assign s = x + y;
    end else begin : g_split
        logic [LOW_W-1:0] s_low;
        logic             c_low;
        logic [NB-1:0]    bc;

        always_comb begin
            logic c;
            c = 1'b0;
            for (int i = 0; i < LOW_W; i++) begin
                s_low[i] = x[i] ^ y[i] ^ c;
                c        = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
            end
            c_low = c;
        end

        assign s[LOW_W-1:0] = s_low;
        assign bc[0]        = c_low;

        for (genvar b = 0; b < NB; b++) begin : g_blk
            localparam int LO = LOW_W + b * BLK_W;
            localparam int BW = (W - LO < BLK_W) ? W - LO : BLK_W;
            if (b < NB - 1) begin : g_mid
                logic [BW:0] t0;
                logic [BW:0] t1;
                assign t0 = {1'b0, x[LO +: BW]} + {1'b0, y[LO +: BW]};
                assign t1 = {1'b0, x[LO +: BW]} + {1'b0, y[LO +: BW]} + (BW+1)'(1);
                assign s[LO +: BW] = bc[b] ? t1[BW-1:0] : t0[BW-1:0];
                assign bc[b+1]     = bc[b] ? t1[BW] : t0[BW];
            end else begin : g_top
                logic [BW-1:0] t0;
                logic [BW-1:0] t1;
                assign t0 = x[LO +: BW] + y[LO +: BW];
                assign t1 = x[LO +: BW] + y[LO +: BW] + BW'(1);
                assign s[LO +: BW] = bc[b] ? t1 : t0;
            end
        end
    end
endmodule

// File: rtl/dadda_mul.sv
`timescale 1ns/1ps
module dadda_mul #(
    parameter int N          = 8,
    parameter int ADDER_KIND = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic [2*N-1:0] product
);
    localparam int PW    = 2 * N;
    localparam int LOW_W = (N / 2 > 0) ? N / 2 : 1;
    localparam int BLK_W = LOW_W;

    typedef struct packed {
        logic [N-1:0]  a;
        logic [N-1:0]  b;
        logic [PW-1:0] p;
    } regs_t;

    regs_t r_d, r_q;

    logic [N*N-1:0] pp_w;
    logic [PW-1:0]  row0_w;
    logic [PW-1:0]  row1_w;
    logic [PW-1:0]  sum_w;

    dm_pp_array #(.N(N)) u_pp (
        .a  (r_q.a),
        .b  (r_q.b),
        .pp (pp_w)
    );

    dm_reduce #(.N(N)) u_tree (
        .pp   (pp_w),
        .row0 (row0_w),
        .row1 (row1_w)
    );

    dm_final_add #(
        .W     (PW),
        .KIND  (ADDER_KIND),
        .LOW_W (LOW_W),
        .BLK_W (BLK_W)
    ) u_cpa (
        .x (row0_w),
        .y (row1_w),
        .s (sum_w)
    );

    always_comb begin
        r_d   = r_q;
        r_d.a = op_a;
        r_d.b = op_b;
        r_d.p = sum_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign product = r_q.p;

    AST_PRODUCT_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.p == PW'($past(r_q.a)) * PW'($past(r_q.b))); // R2

    AST_ROWS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        PW'(row0_w + row1_w) == PW'(r_q.a) * PW'(r_q.b)); // R5

    AST_CPA_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        sum_w == PW'(row0_w + row1_w)); // R6

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.a == $past(r_q.a) && r_q.b == $past(r_q.b)) |=> $stable(r_q.p)); // R4

    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.a == '0 || r_q.b == '0) |=> (r_q.p == '0)); // R7
endmodule

// File: tb/test_dadda_mul.sv
`timescale 1ns/1ps
module test_dadda_mul;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [7:0]  a8, b8;
    logic [15:0] a16, b16;
    logic [15:0] p8;
    logic [31:0] p16h, p16b;

    dadda_mul #(.N(8), .ADDER_KIND(1)) i_dadda_mul (
        .clk(clk), .rst_n(rst_n), .op_a(a8), .op_b(b8), .product(p8));
    dadda_mul #(.N(16), .ADDER_KIND(1)) i_dadda_mul_w (
        .clk(clk), .rst_n(rst_n), .op_a(a16), .op_b(b16), .product(p16h));
    dadda_mul #(.N(16), .ADDER_KIND(0)) i_dadda_mul_wb (
        .clk(clk), .rst_n(rst_n), .op_a(a16), .op_b(b16), .product(p16b));

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // {a, b, expected product} for N=8
    localparam logic [31:0] VEC [8] = '{
        32'h0000_0000, 32'hFFFF_FE01, 32'h8080_4000, 32'h01FF_00FF,
        32'h0FF0_0E10, 32'hAA55_3872, 32'h1234_03A8, 32'h7F81_3FFF
    };

    // two-deep pipeline of expected results
    bit          v1 = 1'b0, v2 = 1'b0;
    logic [15:0] e8_1, e8_2;
    logic [31:0] e16_1, e16_2;
    string       t1, t2;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input bit v, input logic [7:0] a, input logic [7:0] b,
                        input logic [15:0] c, input logic [15:0] d,
                        input logic [15:0] e8, input string tag);
        @(negedge clk);
        if (v2) begin
            chk(t2, {16'h0, p8}, {16'h0, e8_2});
            chk("R5", p16h, e16_2);
            chk("R8", p16b, e16_2);
        end
        v2 = v1; e8_2 = e8_1; e16_2 = e16_1; t2 = t1;
        v1 = v; e8_1 = e8; e16_1 = 32'(c) * 32'(d); t1 = tag;
        a8 = a; b8 = b; a16 = c; b16 = d;
    endtask

    task automatic step(input logic [7:0] a, input logic [7:0] b,
                        input logic [15:0] c, input logic [15:0] d, input string tag);
        push(1'b1, a, b, c, d, 16'(a) * 16'(b), tag);
    endtask

    task automatic flush();
        push(1'b0, 8'h0, 8'h0, 16'h0, 16'h0, 16'h0, "");
        push(1'b0, 8'h0, 8'h0, 16'h0, 16'h0, 16'h0, "");
        push(1'b0, 8'h0, 8'h0, 16'h0, 16'h0, 16'h0, "");
    endtask

    initial begin
        logic [15:0] r1, r2;
        rst_n = 1'b0;
        a8 = 8'hFF; b8 = 8'hFF; a16 = 16'hFFFF; b16 = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R1: cleared while reset is low despite non-zero operands
        chk("R1", {16'h0, p8}, 32'h0);
        chk("R1", p16h, 32'h0);
        chk("R1", p16b, 32'h0);
        rst_n = 1'b1;

        // R3: table streamed back-to-back
        for (int i = 0; i < 8; i++) begin
            r1 = 16'($urandom);
            r2 = 16'($urandom);
            push(1'b1, VEC[i][31:24], VEC[i][23:16], r1, r2, VEC[i][15:0], "R3");
        end

        // R7: zero and all-ones corners
        step(8'h00, 8'hFF, 16'h0000, 16'hFFFF, "R7");
        step(8'hFF, 8'h00, 16'hFFFF, 16'h0000, "R7");
        step(8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, "R7");
        // R6: long carry chains through the select blocks
        step(8'hFF, 8'h81, 16'hFFFF, 16'h8001, "R6");
        step(8'hF0, 8'hF1, 16'hFF00, 16'hFF01, "R6");
        flush();

        // R4: glitch operands between edges, restore before the edge
        step(8'h5A, 8'h3C, 16'h1234, 16'h5678, "R4");
        #2; a8 = 8'hFF; b8 = 8'h00; a16 = 16'hFFFF;
        #2; a8 = 8'h5A; b8 = 8'h3C; a16 = 16'h1234;
        flush();

        // R2: exhaustive N=8, random N=16
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                r1 = 16'($urandom);
                r2 = 16'($urandom);
                step(8'(i), 8'(j), r1, r2, "R2");
            end
        end
        flush();

        // R1: asynchronous clear in mid-run
        step(8'hC3, 8'h5F, 16'hABCD, 16'h9876, "R2");
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1", {16'h0, p8}, 32'h0);
        chk("R1", p16h, 32'h0);
        chk("R1", p16b, 32'h0);
        v1 = 1'b0; v2 = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(8'h9D, 8'hE7, 16'hCAFE, 16'hBEEF, "R1");
        flush();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule